// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes stationary clutter from a pulsed radar range profile. Samples arrive one range bin at a time as signed I/Q pairs with a valid strobe. A start marker flags the first bin of each chirp. For each bin, the block subtracts the sample that the same bin held on the previous chirp from the current sample, separately on I and Q. A target that does not move returns identical samples on every chirp and cancels to zero. A target that moves changes phase or amplitude between chirps and survives the subtraction.

The previous chirp's range line is kept in a register file: one complex entry per bin, with no block memory and no multiplier. Each difference is clamped to the signed sample range. On the first chirp no reference line exists yet, so the output is forced to zero for that whole chirp. This happens after reset and again each time cancellation is switched on. With the enable low, the block forwards its input unchanged. The enable is low in a system that has not yet configured the block.

Top module: `pulse_pair_canceller`

## Requirements
- R1: While `cancel_en` is low, each valid input sample appears unchanged on `out_i`/`out_q` one clock later.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_bin` gives the bin of that sample. The bin is 0 on a sample with `in_chirp_start` high, and one more than the previous valid sample's bin otherwise. It wraps from NUM_BINS-1 to 0.
- R3: With cancellation active and a reference line present, `out_i` = current I − stored I of the same bin, and `out_q` likewise. Both are signed two's complement.
- R4: A difference above 2^(DATA_W-1)−1 is output as 2^(DATA_W-1)−1. A difference below −2^(DATA_W-1) is output as −2^(DATA_W-1).
- R5: After reset, outputs are zero, and the first chirp (plus any samples before its start marker) is output as zero while cancellation is enabled.
- R6: A rising edge of `cancel_en` re-arms the mute. Samples from the edge up to the next start marker, and the whole chirp that marker opens, are output as zero. Cancellation resumes on the chirp after that.
- R7: Two chirps with identical samples in a bin give zero output in that bin on the second chirp.
- R8: Cycles with `in_valid` low do not advance the bin count or change the stored line.
- R9: Every valid sample overwrites the stored entry of its bin, whatever the state of `cancel_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cancel_en | input | 1 | 1 = cancel, 0 = pass-through |
| in_valid | input | 1 | Input sample strobe |
| in_chirp_start | input | 1 | Marks the first bin of a chirp (qualified by `in_valid`) |
| in_i | input | DATA_W | Signed in-phase sample |
| in_q | input | DATA_W | Signed quadrature sample |
| out_valid | output | 1 | Output sample strobe |
| out_bin | output | BIN_W | Range bin of the output sample |
| out_i | output | DATA_W | Signed in-phase result |
| out_q | output | DATA_W | Signed quadrature result |

## Verification
The bench builds the block with DATA_W = 16 and NUM_BINS = 8. The narrow line lets chirps longer than the line reach the bin wrap within a few samples. Keeping full-width samples makes positive and negative saturation reachable with extreme alternating inputs. Many short chirps, idle gaps, enable toggles in mid-chirp and a reset in mid-stream fit within a short run.

// File: rtl/pulse_pair_canceller.sv
module pulse_pair_canceller #(
  parameter int DATA_W   = 16,
  parameter int NUM_BINS = 64,
  parameter int BIN_W    = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cancel_en,
  input  logic              in_valid,
  input  logic              in_chirp_start,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              out_valid,
  output logic [BIN_W-1:0]  out_bin,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  localparam logic [BIN_W-1:0]  LAST_BIN = BIN_W'(NUM_BINS - 1);
  localparam logic [DATA_W-1:0] POS_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX  = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] line_i [NUM_BINS];
  logic [DATA_W-1:0] line_q [NUM_BINS];
  logic [BIN_W-1:0]  next_bin;
  logic              en_q, seen_start, have_line;

  function automatic logic [DATA_W-1:0] sat_sub(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W:0] d;
    d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
    if (d[DATA_W] != d[DATA_W-1]) return d[DATA_W] ? NEG_MAX : POS_MAX;
    return d[DATA_W-1:0];
  endfunction

  wire              arm      = cancel_en & ~en_q;
  wire [BIN_W-1:0]  cur_bin  = in_chirp_start ? '0 : next_bin;
  wire              seen_eff = seen_start & ~arm;
  wire              have_eff = have_line & ~arm;
  wire              line_ok  = in_chirp_start ? seen_eff : have_eff;
  wire [DATA_W-1:0] diff_i   = sat_sub(in_i, line_i[cur_bin]);
  wire [DATA_W-1:0] diff_q   = sat_sub(in_q, line_q[cur_bin]);
  wire [DATA_W-1:0] res_i    = !cancel_en ? in_i : (line_ok ? diff_i : '0);
  wire [DATA_W-1:0] res_q    = !cancel_en ? in_q : (line_ok ? diff_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      seen_start <= 1'b0;
      have_line  <= 1'b0;
      next_bin   <= '0;
      out_valid  <= 1'b0;
      out_bin    <= '0;
      out_i      <= '0;
      out_q      <= '0;
      for (int k = 0; k < NUM_BINS; k++) begin
        line_i[k] <= '0;
        line_q[k] <= '0;
      end
    end else begin
      en_q      <= cancel_en;
      out_valid <= in_valid;
      if (in_valid && in_chirp_start) begin
        seen_start <= 1'b1;
        have_line  <= seen_eff;
      end else if (arm) begin
        seen_start <= 1'b0;
        have_line  <= 1'b0;
      end
      if (in_valid) begin
        line_i[cur_bin] <= in_i;
        line_q[cur_bin] <= in_q;
        next_bin        <= (cur_bin == LAST_BIN) ? '0 : cur_bin + 1'b1;
        out_bin         <= cur_bin;
        out_i           <= res_i;
        out_q           <= res_q;
      end
    end
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cancel_en) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_bin_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chirp_start) |=> (out_bin == '0));

  a_r6_rearm_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cancel_en && !en_q) |=> (out_i == '0 && out_q == '0));

  a_r8_gap_holds_bin: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(next_bin));
endmodule

// File: tb/pulse_pair_canceller_test.sv
module pulse_pair_canceller_test;
  localparam int CLK_PERIOD = 10;
  localparam int BINS = 8;
  localparam int DW = 16;
  localparam int BW = 3;

  logic clk = 0, rst_n = 0, cancel_en = 0, in_valid = 0, in_chirp_start = 0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic [BW-1:0] out_bin;
  logic [DW-1:0] out_i, out_q;

  pulse_pair_canceller #(.DATA_W(DW), .NUM_BINS(BINS), .BIN_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cancel_en(cancel_en), .in_valid(in_valid),
    .in_chirp_start(in_chirp_start), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i), .out_q(out_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, chk_on = 0;

  int prev_i [BINS], prev_q [BINS];
  int bin_next = 0, chirps_armed = 0;
  bit en_prev = 0, after_reset = 1, last_valid = 0;
  bit exp_valid = 0;
  int exp_bin = 0, exp_i = 0, exp_q = 0;
  string tag_d = "R5", tag_b = "R2";

  function automatic int clamp(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < BINS; k++) begin prev_i[k] = 0; prev_q[k] = 0; end
      bin_next = 0; chirps_armed = 0; en_prev = 0; after_reset = 1; last_valid = 0;
      exp_valid = 0; exp_bin = 0; exp_i = 0; exp_q = 0;
    end else begin
      if (cancel_en && !en_prev) chirps_armed = 0;
      if (!cancel_en) after_reset = 0;
      en_prev = cancel_en;
      exp_valid = in_valid;
      if (in_valid) begin
        int b, ci, cq, di, dq;
        b = in_chirp_start ? 0 : bin_next;
        if (in_chirp_start) chirps_armed++;
        ci = $signed(in_i); cq = $signed(in_q);
        tag_b = (!last_valid && !in_chirp_start) ? "R8" : "R2";
        if (!cancel_en) begin
          exp_i = ci; exp_q = cq; tag_d = "R1";
        end else if (chirps_armed < 2) begin
          exp_i = 0; exp_q = 0; tag_d = after_reset ? "R5" : "R6";
        end else begin
          di = ci - prev_i[b]; dq = cq - prev_q[b];
          exp_i = clamp(di); exp_q = clamp(dq);
          if (exp_i != di || exp_q != dq) tag_d = "R4";
          else if (di == 0 && dq == 0) tag_d = "R7";
          else tag_d = "R3";
        end
        prev_i[b] = ci; prev_q[b] = cq;
        exp_bin = b;
        bin_next = (b == BINS-1) ? 0 : b + 1;
      end
      last_valid = in_valid;
    end
  end

  task automatic check(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (chk_on && rst_n) begin
    check("R2", int'(out_valid), int'(exp_valid), "out_valid");
    if (exp_valid) begin
      check(tag_b, int'(out_bin), exp_bin, "out_bin");
      check(tag_d, int'($signed(out_i)), exp_i, "out_i");
      check(tag_d, int'($signed(out_q)), exp_q, "out_q");
    end
  end

  task automatic put(input int i, input int q, input bit start);
    @(negedge clk);
    in_valid = 1; in_chirp_start = start; in_i = DW'(i); in_q = DW'(q);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_chirp_start = 0;
    end
  endtask

  task automatic chirp(input int len, input int kind, input int k, input int gap);
    for (int b = 0; b < len; b++) begin
      int vi, vq;
      case (kind)
        0: begin vi = b*1000 - 3000; vq = 500 - b*700; end
        1: begin vi = b*1000 - 3000 + k*311; vq = 500 - b*700 - k*97; end
        2: begin vi = ((b % 2) == (k % 2)) ? 32767 : -32768; vq = -1 - vi; end
        default: begin vi = int'($signed(16'($urandom))); vq = int'($signed(16'($urandom))); end
      endcase
      put(vi, vq, b == 0);
      if (gap > 0 && (b % 3) == 2) idle(gap);
    end
    idle(1);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; in_valid = 0; in_chirp_start = 0;
    idle(3);
    check("R5", int'(out_valid), 0, "reset out_valid");
    check("R5", int'(out_i), 0, "reset out_i");
    check("R5", int'(out_q), 0, "reset out_q");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    chk_on = 1;
    // R1 pass-through
    chirp(BINS, 0, 0, 0);
    chirp(BINS, 3, 0, 0);
    // R6 enable rise, then R3/R7 with gaps (R8)
    cancel_en = 1;
    chirp(BINS, 0, 0, 0);
    chirp(BINS, 0, 0, 1);
    chirp(BINS, 1, 1, 2);
    chirp(BINS, 1, 2, 0);
    // R2 wrap past last bin
    chirp(BINS + 3, 1, 3, 0);
    chirp(BINS + 3, 1, 4, 1);
    // R4 saturation both ways
    chirp(BINS, 2, 0, 0);
    chirp(BINS, 2, 1, 0);
    chirp(BINS, 2, 2, 1);
    // R9 line written while disabled, then re-armed mid-chirp
    cancel_en = 0;
    chirp(BINS, 1, 9, 0);
    put(11, 22, 1); put(33, 44, 0);
    cancel_en = 1;
    put(55, 66, 0); put(77, 88, 0); idle(1);
    chirp(BINS, 0, 0, 0);
    chirp(BINS, 1, 5, 0);
    // R5 reset mid-stream
    do_reset();
    chirp(BINS, 0, 0, 0);
    chirp(BINS, 1, 6, 0);
    // random chirps
    for (int n = 0; n < 60; n++) begin
      if (($urandom % 9) == 0) cancel_en = ~cancel_en;
      chirp(1 + ($urandom % (BINS + 4)), $urandom % 4, n, $urandom % 2);
    end
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule